// File: doc/BRIEF.md
# Chained Receive DMA Channel

This block moves a stream of peripheral data words into memory. It holds two buffer descriptors, each an address and a remaining transfer count: the active one and a queued one. Every datum the peripheral offers is passed straight through to a single memory write port. The address comes from the active descriptor. The active address then steps by the transfer size and the active count drops by one.

When the active count runs out and the queued count is nonzero, the queued descriptor becomes active in the same clock and the queued slot is zeroed. The datum that follows then lands in the new buffer with no idle cycle. Software refills the queued slot while the active buffer fills. Two sticky flags report that a buffer ended and that the channel has run dry. An interrupt line follows the buffer-end flag when a mask bit allows it.

Top module: `rxdma_chain`

## Requirements
- R1: After reset both addresses and both counts read 0, the channel is disabled, both flags are clear, irq is low, and in_ready and mem_valid are low.
- R2: A datum moves when in_valid, mem_ready, the enable bit and a nonzero active count are all true. The channel drives mem_valid = in_valid and in_ready = mem_ready while enabled with a nonzero count, and holds both low otherwise. It also drives mem_addr = active address and mem_data = in_data in that same cycle.
- R3: Each moved datum decrements the active count by one. It advances the active address by 1, 2 or 4 for a size field (config bits 1:0) of 0, 1 or 2, and by 4 for a size field of 3.
- R4: When the datum that takes the active count from 1 to 0 moves and the queued count is nonzero, the queued address and count become active on that clock, and the queued address and count become 0.
- R5: When that last datum moves and the queued count is 0, the active count stays 0, no further datum moves, and the run-dry flag (status bit 2) sets.
- R6: The buffer-end flag (status bit 1) sets on every move that takes the active count from 1 to 0, including one that chains. Both flags hold until cleared.
- R7: A register write of a nonzero value to either count (offset 1 or 3) clears both flags. A write of zero leaves them. A flag set on the same clock takes priority over the clear.
- R8: A software write to an address or count on the same clock as a move takes priority over the hardware update of that field. The next datum uses the written address.
- R9: A control write (offset 4) with bit 0 set enables the channel and one with bit 1 set disables it; disable wins when both are set. Status bit 0 reports the enable state, and a disabled channel moves nothing.
- R10: Register reads are combinational on reg_addr and show live state at any time. Offsets: 0 active address, 1 active count, 2 queued address, 3 queued count, 4 status {full, end, enabled} in bits 2:0, 5 config {mask, size} in bits 2:0.
- R11: irq equals the buffer-end flag ANDed with the interrupt mask (config bit 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Peripheral datum available |
| in_data | input | DATA_W | Peripheral datum |
| in_ready | output | 1 | Datum accepted this cycle when in_valid is high |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | DATA_W | Write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| irq | output | 1 | Masked buffer-end interrupt |

## Verification
The handshake, the write address and data, irq and the read data are combinational on registered state, so they are due in the cycle of the stimulus. Address, count, flag and enable updates are due one clock after the edge that samples the move or the write. The bench drives inputs just after a rising edge and keeps a behavioural model that it steps on the same rising edge. It compares every output against that model at the falling edge, so each result is read in the cycle it is due. The directed checks use the same timing for the chain swap, the dry stop, flag clearing, write collisions and enable control.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } xfer_size_e;

   localparam logic [2:0] OFS_CUR_ADR = 3'd0;
   localparam logic [2:0] OFS_CUR_CNT = 3'd1;
   localparam logic [2:0] OFS_NXT_ADR = 3'd2;
   localparam logic [2:0] OFS_NXT_CNT = 3'd3;
   localparam logic [2:0] OFS_CTRL    = 3'd4;
   localparam logic [2:0] OFS_CFG     = 3'd5;
endpackage

// File: rtl/rxdma_addr_step.sv
module rxdma_addr_step
   import rxdma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter bit PROG_SIZE   = 1'b1,
   parameter int FIXED_BYTES = 4
) (
   input  xfer_size_e          size_i,
   output logic [ADDR_W-1:0]   step_o
);
   if (FIXED_BYTES != 1 && FIXED_BYTES != 2 && FIXED_BYTES != 4) begin : g_bad_fixed
      $error("rxdma_addr_step: FIXED_BYTES must be 1, 2 or 4");
   end

   if (PROG_SIZE) begin : g_prog
      always_comb begin
         case (size_i)
            SZ_BYTE: step_o = ADDR_W'(1);
            SZ_HALF: step_o = ADDR_W'(2);
            default: step_o = ADDR_W'(4);
         endcase
      end
   end else begin : g_fixed
      logic unused_size;
      assign unused_size = ^size_i;
      assign step_o      = ADDR_W'(FIXED_BYTES);
   end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
   import rxdma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ctrl_i,
   input  logic        wr_cfg_i,
   input  logic [2:0]  wbits_i,
   output logic        en_o,
   output logic        mask_o,
   output xfer_size_e  size_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         mask_o <= 1'b0;
         size_o <= SZ_BYTE;
      end else begin
         if (wr_ctrl_i) begin
            if (wbits_i[1])      en_o <= 1'b0;
            else if (wbits_i[0]) en_o <= 1'b1;
         end
         if (wr_cfg_i) begin
            mask_o <= wbits_i[2];
            size_o <= xfer_size_e'(wbits_i[1:0]);
         end
      end
   end

   // R9: a control write carrying the disable bit always leaves the channel off
   p_disable_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl_i && wbits_i[1]) |=> !en_o);
endmodule

// File: rtl/rxdma_core.sv
module rxdma_core #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_i,
   input  logic [ADDR_W-1:0] step_i,
   input  logic              wr_cadr_i,
   input  logic              wr_ccnt_i,
   input  logic              wr_nadr_i,
   input  logic              wr_ncnt_i,
   input  logic [ADDR_W-1:0] wadr_i,
   input  logic [CNT_W-1:0]  wcnt_i,
   output logic [ADDR_W-1:0] cur_adr_o,
   output logic [CNT_W-1:0]  cur_cnt_o,
   output logic [ADDR_W-1:0] nxt_adr_o,
   output logic [CNT_W-1:0]  nxt_cnt_o,
   output logic              end_flag_o,
   output logic              dry_flag_o
);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic last_beat, chain, flag_clr;
   assign last_beat = xfer_i && (cur_cnt_o == CNT_ONE);
   assign chain     = last_beat && (nxt_cnt_o != CNT_ZERO);
   assign flag_clr  = (wr_ccnt_i || wr_ncnt_i) && (wcnt_i != CNT_ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_adr_o  <= '0;
         cur_cnt_o  <= '0;
         nxt_adr_o  <= '0;
         nxt_cnt_o  <= '0;
         end_flag_o <= 1'b0;
         dry_flag_o <= 1'b0;
      end else begin
         // active address: software write, then chain swap, then step
         if (wr_cadr_i)   cur_adr_o <= wadr_i;
         else if (chain)  cur_adr_o <= nxt_adr_o;
         else if (xfer_i) cur_adr_o <= cur_adr_o + step_i;

         if (wr_ccnt_i)   cur_cnt_o <= wcnt_i;
         else if (chain)  cur_cnt_o <= nxt_cnt_o;
         else if (xfer_i) cur_cnt_o <= cur_cnt_o - CNT_ONE;

         if (wr_nadr_i)   nxt_adr_o <= wadr_i;
         else if (chain)  nxt_adr_o <= '0;

         if (wr_ncnt_i)   nxt_cnt_o <= wcnt_i;
         else if (chain)  nxt_cnt_o <= '0;

         if (last_beat)     end_flag_o <= 1'b1;
         else if (flag_clr) end_flag_o <= 1'b0;

         if (last_beat && !chain) dry_flag_o <= 1'b1;
         else if (flag_clr)       dry_flag_o <= 1'b0;
      end
   end

   // R3: an ordinary move takes exactly one off the active count
   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && !wr_ccnt_i && cur_cnt_o > CNT_ONE) |=> (cur_cnt_o == $past(cur_cnt_o) - CNT_ONE));
   // R4: a chaining move hands the queued count over and empties the slot
   p_chain_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && cur_cnt_o == CNT_ONE && nxt_cnt_o != CNT_ZERO && !wr_ccnt_i && !wr_ncnt_i)
      |=> (cur_cnt_o == $past(nxt_cnt_o) && nxt_cnt_o == CNT_ZERO));
   // R5: nothing is moved while the active count is exhausted
   p_no_move_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_cnt_o == CNT_ZERO) |-> !xfer_i);
   // R6: the last move of a buffer always raises the end flag
   p_end_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && cur_cnt_o == CNT_ONE) |=> end_flag_o);
   // R6: the end flag holds without a nonzero count write
   p_end_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (end_flag_o && !(wr_ccnt_i && wcnt_i != CNT_ZERO) && !(wr_ncnt_i && wcnt_i != CNT_ZERO))
      |=> end_flag_o);
endmodule

// File: rtl/rxdma_chain.sv
module rxdma_chain
   import rxdma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 32,
   parameter int REG_W       = 32,
   parameter bit PROG_SIZE   = 1'b1,
   parameter int FIXED_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);
   if (ADDR_W > REG_W || CNT_W > REG_W || CNT_W < 2 || REG_W < 3) begin : g_bad_widths
      $error("rxdma_chain: address and count widths must fit the register word");
   end

   logic              en, mask, end_flag, dry_flag, active, xfer;
   xfer_size_e        size;
   logic [ADDR_W-1:0] step, cur_adr, nxt_adr;
   logic [CNT_W-1:0]  cur_cnt, nxt_cnt;

   rxdma_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl_i(reg_we && reg_addr == OFS_CTRL),
      .wr_cfg_i (reg_we && reg_addr == OFS_CFG),
      .wbits_i(reg_wdata[2:0]),
      .en_o(en), .mask_o(mask), .size_o(size)
   );

   rxdma_addr_step #(.ADDR_W(ADDR_W), .PROG_SIZE(PROG_SIZE), .FIXED_BYTES(FIXED_BYTES)) u_step (
      .size_i(size), .step_o(step)
   );

   rxdma_core #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .step_i(step),
      .wr_cadr_i(reg_we && reg_addr == OFS_CUR_ADR),
      .wr_ccnt_i(reg_we && reg_addr == OFS_CUR_CNT),
      .wr_nadr_i(reg_we && reg_addr == OFS_NXT_ADR),
      .wr_ncnt_i(reg_we && reg_addr == OFS_NXT_CNT),
      .wadr_i(reg_wdata[ADDR_W-1:0]), .wcnt_i(reg_wdata[CNT_W-1:0]),
      .cur_adr_o(cur_adr), .cur_cnt_o(cur_cnt),
      .nxt_adr_o(nxt_adr), .nxt_cnt_o(nxt_cnt),
      .end_flag_o(end_flag), .dry_flag_o(dry_flag)
   );

   assign active    = en && (cur_cnt != '0);
   assign xfer      = in_valid && mem_ready && active;
   assign in_ready  = mem_ready && active;
   assign mem_valid = in_valid && active;
   assign mem_addr  = cur_adr;
   assign mem_data  = in_data;
   assign irq       = end_flag && mask;

   always_comb begin
      case (reg_addr)
         OFS_CUR_ADR: reg_rdata = REG_W'(cur_adr);
         OFS_CUR_CNT: reg_rdata = REG_W'(cur_cnt);
         OFS_NXT_ADR: reg_rdata = REG_W'(nxt_adr);
         OFS_NXT_CNT: reg_rdata = REG_W'(nxt_cnt);
         OFS_CTRL:    reg_rdata = REG_W'({dry_flag, end_flag, en});
         OFS_CFG:     reg_rdata = REG_W'({mask, size});
         default:     reg_rdata = '0;
      endcase
   end

   // R2: every write request the memory takes consumes one peripheral datum
   p_handshake_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |-> (in_valid && in_ready));
   // R8: a software address write wins over the hardware step
   p_adr_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_CUR_ADR) |=> (mem_addr == $past(reg_wdata[ADDR_W-1:0])));
endmodule

// File: tb/rxdma_chain_tb.sv
module rxdma_chain_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, mem_ready = 1'b0, reg_we = 1'b0;
   logic [31:0] in_data = '0, reg_wdata = '0;
   logic [2:0]  reg_addr = '0;
   logic        in_ready, mem_valid, irq;
   logic [31:0] mem_addr, mem_data, reg_rdata;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rxdma_chain u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   // behavioural reference state
   logic [31:0] m_cadr, m_nadr;
   int unsigned m_ccnt, m_ncnt;
   bit m_en, m_end, m_dry, m_mask;
   int unsigned m_size;

   function automatic int unsigned step_of(int unsigned sz);
      return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cadr = 0; m_nadr = 0; m_ccnt = 0; m_ncnt = 0;
         m_en = 0; m_end = 0; m_dry = 0; m_mask = 0; m_size = 0;
      end else begin
         bit mv, last, swp, clr;
         logic [31:0] ca, na;
         int unsigned cc, nc;
         mv   = in_valid && mem_ready && m_en && m_ccnt != 0;
         last = mv && m_ccnt == 1;
         swp  = last && m_ncnt != 0;
         ca = m_cadr; cc = m_ccnt; na = m_nadr; nc = m_ncnt;
         if (mv) begin ca = m_cadr + step_of(m_size); cc = m_ccnt - 1; end
         if (swp) begin ca = m_nadr; cc = m_ncnt; na = 0; nc = 0; end
         clr = 0;
         if (reg_we) begin
            case (reg_addr)
               3'd0: ca = reg_wdata;
               3'd1: begin cc = reg_wdata[15:0]; clr = reg_wdata[15:0] != 0; end
               3'd2: na = reg_wdata;
               3'd3: begin nc = reg_wdata[15:0]; clr = reg_wdata[15:0] != 0; end
               3'd4: if (reg_wdata[1]) m_en = 0; else if (reg_wdata[0]) m_en = 1;
               3'd5: begin m_size = reg_wdata[1:0]; m_mask = reg_wdata[2]; end
               default: ;
            endcase
         end
         if (last) m_end = 1; else if (clr) m_end = 0;
         if (last && !swp) m_dry = 1; else if (clr) m_dry = 0;
         m_cadr = ca; m_ccnt = cc; m_nadr = na; m_ncnt = nc;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit act;
         logic [31:0] er;
         act = m_en && m_ccnt != 0;
         case (reg_addr)
            3'd0: er = m_cadr;
            3'd1: er = m_ccnt;
            3'd2: er = m_nadr;
            3'd3: er = m_ncnt;
            3'd4: er = {29'd0, m_dry, m_end, m_en};
            3'd5: er = {29'd0, m_mask, m_size[1:0]};
            default: er = 0;
         endcase
         chk("R9 in_ready", {31'd0, in_ready}, {31'd0, mem_ready && act});
         chk("R2 mem_valid", {31'd0, mem_valid}, {31'd0, in_valid && act});
         chk("R2 mem_addr", mem_addr, m_cadr);
         chk("R2 mem_data", mem_data, in_data);
         chk("R11 irq", {31'd0, irq}, {31'd0, m_end && m_mask});
         chk("R10 reg_rdata", reg_rdata, er);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
      reg_addr = a;
      @(negedge clk);
      chk(tag, reg_rdata, exp);
      @(posedge clk); #1;
   endtask

   task automatic stream(input int n);
      int got = 0;
      for (int i = 0; got < n; i++) begin
         in_valid = 1; mem_ready = (i % 3) != 2; in_data = 32'hA500 + i;
         @(negedge clk);
         if (in_ready) got++;
         @(posedge clk); #1;
      end
      in_valid = 0; mem_ready = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      rst_n = 1;
      // R1 reset state
      rd_chk("R1 cur adr", 3'd0, 0);
      rd_chk("R1 cur cnt", 3'd1, 0);
      rd_chk("R1 status", 3'd4, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      // word size, mask on, two buffers chained
      wr(3'd5, 32'h6);
      wr(3'd0, 32'h1000); wr(3'd1, 3);
      wr(3'd2, 32'h2000); wr(3'd3, 2);
      wr(3'd4, 32'h1);
      stream(3);
      rd_chk("R4 cur adr after chain", 3'd0, 32'h2000);
      rd_chk("R4 cur cnt after chain", 3'd1, 2);
      rd_chk("R4 nxt cnt zeroed", 3'd3, 0);
      rd_chk("R6 end flag on chain", 3'd4, 3);
      chk("R11 irq on", {31'd0, irq}, 1);
      wr(3'd5, 32'h2);
      chk("R11 irq masked", {31'd0, irq}, 0);
      wr(3'd5, 32'h6);
      stream(2);
      rd_chk("R5 cur cnt dry", 3'd1, 0);
      rd_chk("R5 status dry", 3'd4, 7);
      in_valid = 1; mem_ready = 1;
      @(negedge clk);
      chk("R5 in_ready stops", {31'd0, in_ready}, 0);
      @(posedge clk); #1;
      in_valid = 0; mem_ready = 0;
      // R7 flag clearing
      wr(3'd3, 0);
      rd_chk("R7 zero write keeps", 3'd4, 7);
      wr(3'd3, 5);
      rd_chk("R7 nonzero write clears", 3'd4, 1);
      // R3 sizes
      wr(3'd3, 0);
      wr(3'd5, 32'h0); wr(3'd0, 32'h10); wr(3'd1, 4);
      stream(2);
      rd_chk("R3 byte step", 3'd0, 32'h12);
      wr(3'd5, 32'h1);
      stream(1);
      rd_chk("R3 half step", 3'd0, 32'h14);
      rd_chk("R10 live count", 3'd1, 1);
      // R8 collision of pointer write and move
      wr(3'd1, 100); wr(3'd5, 32'h2);
      in_valid = 1; mem_ready = 1; reg_we = 1; reg_addr = 3'd0; reg_wdata = 32'h8000;
      @(negedge clk);
      chk("R8 move in write cycle", {31'd0, in_ready}, 1);
      @(posedge clk); #1;
      reg_we = 0; in_valid = 0; reg_addr = 3'd1;
      @(negedge clk);
      chk("R8 new address used", mem_addr, 32'h8000);
      chk("R8 count stepped", reg_rdata, 99);
      @(posedge clk); #1;
      // R9 enable control
      wr(3'd4, 32'h2);
      rd_chk("R9 disabled", 3'd4, 0);
      in_valid = 1; mem_ready = 1;
      @(negedge clk);
      chk("R9 no move disabled", {31'd0, in_ready}, 0);
      @(posedge clk); #1;
      in_valid = 0; mem_ready = 0;
      wr(3'd4, 32'h1);
      rd_chk("R9 enabled", 3'd4, 1);
      wr(3'd4, 32'h3);
      rd_chk("R9 disable wins", 3'd4, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule